// File: doc/BRIEF.md
# Programmable Counter/Timer with Latched Output

A 16-bit down counter with a single output bit, meant to sit beside a serial controller and provide either a periodic square wave or a one-shot terminal-count flag. Software writes a 16-bit reload value one byte at a time. A start strobe loads that value and sets the counter running. Each cycle with the tick enable high then counts down by one, and a stop strobe halts it.

In timer mode the counter reloads itself whenever it counts down to zero, and the output flips at each reload. The resulting square wave has a full period of twice the reload value in ticks. In counter mode the output drops low at terminal count and stays low until a stop strobe arrives, while the count keeps wrapping past zero. A capture strobe copies the live count into a holding register, so the upper and lower read bytes always come from the same count value.

Top module: `ctmr_top`

## Requirements
- R1: After reset the counter is stopped, the output is high (1), the count is 0, the reload value is 0 and both read bytes are 0.
- R2: A write with the upper-byte strobe loads the data into bits 15:8 of the reload value, and a write with the lower-byte strobe loads it into bits 7:0. The other byte is left unchanged.
- R3: A start strobe loads the reload value as it stood before that clock edge into the count and sets the counter running. A tick in the same cycle is ignored.
- R4: While the counter is running, each cycle with the tick enable high decrements the count by one. While it is stopped, ticks leave the count unchanged.
- R5: In timer mode (mode input 1), a tick while the count is 1 reloads the reload value and inverts the output. With reload value N, the output holds each level for N ticks.
- R6: In counter mode (mode input 0), a tick while the count is 1 drives the output low. The output stays low and the count continues down through 0 to 0xFFFF and onward.
- R7: A stop strobe clears the running state, holds the count and forces the output high. When start and stop arrive in the same cycle, stop wins.
- R8: A capture strobe latches the count as it stood before that edge, both bytes at once. The read bytes then hold that value until the next capture.
- R9: A reload value of 0 gives a terminal count after 65536 ticks, because the count wraps from 0 to 0xFFFF.
- R10: A start strobe while the counter is running reloads the count and leaves the output level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_hi_we_i | input | 1 | Write strobe for reload bits 15:8 |
| pre_lo_we_i | input | 1 | Write strobe for reload bits 7:0 |
| pre_data_i | input | 8 | Reload byte data |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| timer_mode_i | input | 1 | 1 = timer (square wave), 0 = counter (one-shot latch) |
| tick_i | input | 1 | Count enable |
| rd_cap_i | input | 1 | Capture live count into read bytes |
| val_hi_o | output | 8 | Captured count bits 15:8 |
| val_lo_o | output | 8 | Captured count bits 7:0 |
| out_o | output | 1 | Counter/timer output |

## Verification
The assertions check on every cycle the following:
- a stop always leaves the output high;
- a start loads the reload value;
- a plain tick decrements the count and idle cycles hold it;
- in counter mode a low output stays low;
- the output moves only on a terminal tick;
- the read bytes change only on capture.

Other behaviours need the bench's scenarios:
- the square-wave half period;
- the wrap to 0xFFFF after terminal count;
- the 65536-tick span of a zero reload value;
- the stop-over-start priority;
- byte-lane independence of reload writes.

The bench shows these by comparing against its own cycle model under random strobes and ticks.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic {
    MODE_COUNTER = 1'b0,
    MODE_TIMER   = 1'b1
  } ctmr_mode_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic tick;
  } ctmr_cmd_t;
endpackage

// File: rtl/ctmr_preset.sv
module ctmr_preset #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int W = BYTE_W * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBYTES-1:0] we_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [W-1:0]      preset_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q <= '0;
      else if (we_i[g]) lane_q <= data_i;
    end
    assign preset_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ctmr_cmd_t  cmd_i,
  input  ctmr_mode_e mode_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] cnt_o,
  output logic       run_o,
  output logic       tc_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;

  assign tc_o = run_q & cmd_i.tick & ~cmd_i.start & ~cmd_i.stop
              & (cnt_q == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (cmd_i.stop) begin
      run_d = 1'b0;
    end else if (cmd_i.start) begin
      run_d = 1'b1;
      cnt_d = preset_i;
    end else if (tc_o && mode_i == MODE_TIMER) begin
      cnt_d = preset_i;
    end else if (run_q && cmd_i.tick) begin
      cnt_d = cnt_q - 1'b1;  // counter mode wraps through zero
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/ctmr_wave.sv
module ctmr_wave
  import ctmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_i,
  input  logic       tc_i,
  input  ctmr_mode_e mode_i,
  output logic       out_o
);
  logic out_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= 1'b1;
    else if (stop_i) out_q <= 1'b1;
    else if (tc_i)   out_q <= (mode_i == MODE_TIMER) ? ~out_q : 1'b0;
  end
  assign out_o = out_q;
endmodule

// File: rtl/ctmr_snap.sv
module ctmr_snap #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_o <= '0;
    else if (cap_i) snap_o <= cnt_i;
  end
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pre_hi_we_i,
  input  logic              pre_lo_we_i,
  input  logic [BYTE_W-1:0] pre_data_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              timer_mode_i,
  input  logic              tick_i,
  input  logic              rd_cap_i,
  output logic [BYTE_W-1:0] val_hi_o,
  output logic [BYTE_W-1:0] val_lo_o,
  output logic              out_o
);
  logic [CNT_W-1:0] preset_q, cnt_q, snap_q;
  logic             run_q, tc;
  ctmr_cmd_t        cmd;
  ctmr_mode_e       mode;

  assign cmd  = '{start: start_i, stop: stop_i, tick: tick_i};
  assign mode = ctmr_mode_e'(timer_mode_i);

  ctmr_preset #(.BYTE_W(BYTE_W), .NBYTES(2)) u_preset (
    .clk_i, .rst_ni,
    .we_i    ({pre_hi_we_i, pre_lo_we_i}),
    .data_i  (pre_data_i),
    .preset_o(preset_q)
  );

  ctmr_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .cmd_i   (cmd),
    .mode_i  (mode),
    .preset_i(preset_q),
    .cnt_o   (cnt_q),
    .run_o   (run_q),
    .tc_o    (tc)
  );

  ctmr_wave u_wave (
    .clk_i, .rst_ni,
    .stop_i(stop_i),
    .tc_i  (tc),
    .mode_i(mode),
    .out_o (out_o)
  );

  ctmr_snap #(.W(CNT_W)) u_snap (
    .clk_i, .rst_ni,
    .cap_i (rd_cap_i),
    .cnt_i (cnt_q),
    .snap_o(snap_q)
  );

  assign val_hi_o = snap_q[CNT_W-1:BYTE_W];
  assign val_lo_o = snap_q[BYTE_W-1:0];
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         stop_i,
  input logic         tick_i,
  input logic         timer_mode_i,
  input logic         rd_cap_i,
  input logic         out_i,
  input logic [W-1:0] snap_i,
  input logic [W-1:0] cnt_i,
  input logic         run_i,
  input logic [W-1:0] preset_i
);
  a_r7_stop_forces_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (out_i && !run_i));

  a_r3_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (run_i && cnt_i == $past(preset_i)));

  a_r4_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !start_i && !stop_i && cnt_i != W'(1))
      |=> cnt_i == $past(cnt_i) - 1'b1);

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(cnt_i));

  a_r6_latch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timer_mode_i && !out_i && !stop_i) |=> !out_i);

  a_r5_out_moves_on_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !(run_i && tick_i && !start_i && cnt_i == W'(1))) |=> $stable(out_i));

  a_r8_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cap_i |=> $stable(snap_i));
endmodule

bind ctmr_top ctmr_chk #(.W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .tick_i      (tick_i),
  .timer_mode_i(timer_mode_i),
  .rd_cap_i    (rd_cap_i),
  .out_i       (out_o),
  .snap_i      ({val_hi_o, val_lo_o}),
  .cnt_i       (cnt_q),
  .run_i       (run_q),
  .preset_i    (preset_q)
);

// File: tb/ctmr_top_test.sv
`timescale 1ns/1ps
module ctmr_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pre_hi_we_i = 0, pre_lo_we_i = 0;
  logic [7:0] pre_data_i = '0;
  logic       start_i = 0, stop_i = 0, timer_mode_i = 0, tick_i = 0, rd_cap_i = 0;
  logic [7:0] val_hi_o, val_lo_o;
  logic       out_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_pre = 0, m_cnt = 0, m_snap = 0;
  logic        m_run = 0, m_out = 1;

  always #10 clk_i = ~clk_i;

  ctmr_top uut (.*);

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic void model_step();
    logic [15:0] pre_old = m_pre;
    if (rd_cap_i) m_snap = m_cnt;
    if (stop_i) begin
      m_run = 0; m_out = 1;
    end else if (start_i) begin
      m_run = 1; m_cnt = pre_old;
    end else if (m_run && tick_i) begin
      if (m_cnt == 16'd1) begin
        if (timer_mode_i) begin m_cnt = pre_old; m_out = ~m_out; end
        else begin m_cnt = 16'd0; m_out = 0; end
      end else m_cnt = m_cnt - 16'd1;
    end
    if (pre_hi_we_i) m_pre[15:8] = pre_data_i;
    if (pre_lo_we_i) m_pre[7:0]  = pre_data_i;
  endfunction

  task automatic step();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk(timer_mode_i ? "R5 out" : "R6 out", {15'd0, out_o}, {15'd0, m_out});
    chk("R8 read", {val_hi_o, val_lo_o}, m_snap);
    pre_hi_we_i = 0; pre_lo_we_i = 0; start_i = 0; stop_i = 0;
    tick_i = 0; rd_cap_i = 0;
  endtask

  task automatic wr(logic hi, logic [7:0] d);
    pre_data_i = d; if (hi) pre_hi_we_i = 1; else pre_lo_we_i = 1; step();
  endtask
  task automatic cap(); rd_cap_i = 1; step(); endtask
  task automatic tk(int n); for (int i = 0; i < n; i++) begin tick_i = 1; step(); end endtask
  task automatic go(); start_i = 1; step(); endtask
  task automatic halt(); stop_i = 1; step(); endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c7a1));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk("R1 out", {15'd0, out_o}, 16'd1);
    cap(); chk("R1 count", {val_hi_o, val_lo_o}, 16'h0000);
    // R2/R3 byte writes and start
    wr(0, 8'h03); wr(1, 8'h00);
    timer_mode_i = 0; go(); cap();
    chk("R3 loaded", {val_hi_o, val_lo_o}, 16'h0003);
    tk(1); cap(); chk("R4 dec", {val_hi_o, val_lo_o}, 16'h0002);
    tk(1); chk("R6 before tc", {15'd0, out_o}, 16'd1);
    tk(1); chk("R6 low at tc", {15'd0, out_o}, 16'd0);
    tk(1); cap(); chk("R6 wrap", {val_hi_o, val_lo_o}, 16'hFFFF);
    chk("R6 still low", {15'd0, out_o}, 16'd0);
    go(); chk("R10 out kept", {15'd0, out_o}, 16'd0);
    cap(); chk("R10 reload", {val_hi_o, val_lo_o}, 16'h0003);
    halt(); chk("R7 out high", {15'd0, out_o}, 16'd1);
    tk(3); cap(); chk("R4 stopped hold", {val_hi_o, val_lo_o}, 16'h0003);
    start_i = 1; stop_i = 1; step(); tk(2); cap();
    chk("R7 stop wins", {val_hi_o, val_lo_o}, 16'h0003);
    // R5 timer mode
    wr(0, 8'h02); timer_mode_i = 1; go();
    tk(1); chk("R5 half", {15'd0, out_o}, 16'd1);
    tk(1); chk("R5 toggle", {15'd0, out_o}, 16'd0);
    cap(); chk("R5 reload", {val_hi_o, val_lo_o}, 16'h0002);
    tk(2); chk("R5 toggle back", {15'd0, out_o}, 16'd1);
    tk(1); go(); cap(); chk("R10 restart", {val_hi_o, val_lo_o}, 16'h0002);
    tk(3); chk("R8 held", {val_hi_o, val_lo_o}, 16'h0002);
    // R2 upper byte only
    wr(1, 8'hAB); go(); cap(); chk("R2 hi only", {val_hi_o, val_lo_o}, 16'hAB02);
    // R9 zero reload, counter mode
    halt(); wr(1, 8'h00); wr(0, 8'h00); timer_mode_i = 0; go();
    tk(65535); chk("R9 no tc yet", {15'd0, out_o}, 16'd1);
    tk(1); chk("R9 tc at 65536", {15'd0, out_o}, 16'd0);
    halt();
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) begin pre_lo_we_i = 1; pre_data_i = 8'($urandom_range(1, 6)); end
      else if (r < 6) begin pre_hi_we_i = 1; pre_data_i = 8'($urandom_range(0, 1) ? 0 : 0); end
      if ($urandom_range(0, 99) < 3) start_i = 1;
      if ($urandom_range(0, 99) < 2) stop_i = 1;
      if ($urandom_range(0, 199) < 1) timer_mode_i = ~timer_mode_i;
      tick_i = ($urandom_range(0, 99) < 70);
      rd_cap_i = ($urandom_range(0, 99) < 30);
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule